// File: doc/BRIEF.md
# Counted Breakpoint and Watchpoint Unit

This block listens passively to a processor's instruction fetch bus and data bus and raises debug events for an on-chip debug controller. It never stalls either bus. It holds two comparators that watch fetch addresses and one comparator that watches data addresses. Each comparator has its own occurrence threshold, so it can wait for a chosen number of matches before it reports.

Each comparator is set to one of two modes. In halt mode its event drives a halt request toward the processor's clock control. In watch mode its event only pulses a hit line, and the program keeps running. A dedicated per-comparator event vector is also brought out, so that neighbouring logic such as a fault-injection write strobe can react in the same cycle.

A single-cycle configuration write loads one comparator completely: its address, count, mode, direction filter and enable. That write also re-arms the comparator. Once a comparator has fired, it stays silent until it is written again. A sticky status vector records which comparators have fired. All ports are plain control and status pins. No port carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `bpwp_unit`

## Requirements
- R1: Comparators 0 and 1 match a cycle with `if_valid`=1 and `if_addr` equal to their programmed address. Comparator 2 (index NUM_I) matches only cycles with `db_valid`=1 and `db_addr` equal to its address. Cycles whose valid bit is low are never counted.
- R2: With a programmed count N, a comparator fires on the Nth match after it was last configured. Counts of 0 and 1 both fire on the first match.
- R3: When a comparator fires in halt mode (`cfg_halt`=1), `halt_req` pulses and `wp_hit` stays low. When it fires in watch mode (`cfg_halt`=0), `wp_hit` pulses and `halt_req` stays low.
- R4: Every event is a single-cycle pulse on `hit_src[i]`, and on `halt_req` or `wp_hit`. The pulse appears in the cycle right after the clock edge that sampled the matching bus cycle.
- R5: After firing, a comparator ignores all further matches until a configuration write to that comparator loads `cfg_enable`=1.
- R6: `status[i]` is set when comparator i fires. It stays set until a configuration write to comparator i clears it. It is 0 after reset.
- R7: The data comparator's `cfg_dir` field works as follows. Bit 0 allows reads (`db_write`=0) and bit 1 allows writes (`db_write`=1). The value 2'b11 accepts either kind, and 2'b00 matches nothing. The field is ignored by the fetch comparators.
- R8: A configuration write clears the comparator's occurrence count. A match in the same cycle as a configuration write to that comparator is not counted and does not fire.
- R9: A comparator configured with `cfg_enable`=0 never fires.
- R10: Several comparators that fire on the same edge each pulse their own `hit_src` bit. `halt_req` and `wp_hit` can then both be high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid | input | 1 | Fetch bus cycle valid |
| if_addr | input | AW | Fetch address |
| db_valid | input | 1 | Data bus cycle valid |
| db_write | input | 1 | Data bus cycle is a write |
| db_addr | input | AW | Data address |
| cfg_we | input | 1 | Load one comparator's configuration |
| cfg_idx | input | IW | Comparator to load (NUM_I is the data one) |
| cfg_addr | input | AW | Address to match |
| cfg_count | input | CW | Occurrence count N |
| cfg_halt | input | 1 | 1 = halt mode, 0 = watch mode |
| cfg_enable | input | 1 | Arm the comparator |
| cfg_dir | input | 2 | Data direction filter (bit0 read, bit1 write) |
| halt_req | output | 1 | Halt request pulse |
| wp_hit | output | 1 | Watch hit pulse |
| hit_src | output | NUM_I+1 | Per-comparator event pulse |
| status | output | NUM_I+1 | Sticky fired flags |

## Verification
The bound checker runs on every cycle and covers the following:
- every event is a one-cycle pulse that cannot repeat on the next edge;
- every event follows a valid bus cycle;
- the halt and watch lines agree with the event vector;
- a status bit is set whenever its comparator fires and holds until its comparator is reconfigured;
- a configuration write suppresses a same-cycle fire.

Only the bench's scenarios can show the exact Nth-match counting, the read/write filtering of the data comparator, the counter restart on reconfiguration and the correct address comparisons. These depend on the programmed values and on the history of bus traffic.

// File: rtl/bpwp_pkg.sv
package bpwp_pkg;
  typedef enum logic {
    MODE_WATCH = 1'b0,
    MODE_HALT  = 1'b1
  } bp_mode_e;

  localparam int DIR_RD_BIT = 0;
  localparam int DIR_WR_BIT = 1;
endpackage

// File: rtl/bpwp_match.sv
module bpwp_match #(
  parameter int AW      = 16,
  parameter bit IS_DATA = 1'b0
) (
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [AW-1:0] ref_addr,
  input  logic [1:0]    dir,
  output logic          hit
);
  import bpwp_pkg::*;

  logic dir_ok;

  generate
    if (IS_DATA) begin : g_data
      always_comb dir_ok = bus_write ? dir[DIR_WR_BIT] : dir[DIR_RD_BIT];
    end else begin : g_fetch
      logic unused_dir;
      always_comb begin
        unused_dir = ^{dir, bus_write};
        dir_ok     = 1'b1;
      end
    end
  endgenerate

  always_comb hit = bus_valid && (bus_addr == ref_addr) && dir_ok;
endmodule

// File: rtl/bpwp_slot.sv
module bpwp_slot #(
  parameter int AW      = 16,
  parameter int CW      = 8,
  parameter bit IS_DATA = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_halt,
  input  logic          cfg_enable,
  input  logic [1:0]    cfg_dir,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  output logic          fire,
  output logic          halt_mode,
  output logic          sticky
);
  import bpwp_pkg::*;

  logic [AW-1:0] ref_addr;
  logic [CW-1:0] target;
  logic [CW-1:0] occ;
  logic [1:0]    dir;
  bp_mode_e      mode;
  logic          armed;
  logic          hit;
  logic [CW:0]   occ_next;
  logic          last;

  bpwp_match #(.AW(AW), .IS_DATA(IS_DATA)) i_match (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .ref_addr  (ref_addr),
    .dir       (dir),
    .hit       (hit)
  );

  // a target of 0 or 1 both make the first match the last one
  always_comb begin
    occ_next = {1'b0, occ} + 1'b1;
    last     = occ_next >= {1'b0, target};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_addr <= '0;
      target   <= '0;
      occ      <= '0;
      dir      <= '0;
      mode     <= MODE_WATCH;
      armed    <= 1'b0;
      fire     <= 1'b0;
      sticky   <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (cfg_load) begin
        ref_addr <= cfg_addr;
        target   <= cfg_count;
        dir      <= cfg_dir;
        mode     <= cfg_halt ? MODE_HALT : MODE_WATCH;
        armed    <= cfg_enable;
        occ      <= '0;
        sticky   <= 1'b0;
      end else if (armed && hit) begin
        if (last) begin
          fire   <= 1'b1;
          armed  <= 1'b0;
          sticky <= 1'b1;
        end else begin
          occ <= occ_next[CW-1:0];
        end
      end
    end
  end

  always_comb halt_mode = (mode == MODE_HALT);
endmodule

// File: rtl/bpwp_unit.sv
module bpwp_unit #(
  parameter int NUM_I = 2,
  parameter int AW    = 16,
  parameter int CW    = 8,
  localparam int NCMP = NUM_I + 1,
  localparam int IW   = (NCMP > 1) ? $clog2(NCMP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_valid,
  input  logic [AW-1:0]   if_addr,
  input  logic            db_valid,
  input  logic            db_write,
  input  logic [AW-1:0]   db_addr,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [CW-1:0]   cfg_count,
  input  logic            cfg_halt,
  input  logic            cfg_enable,
  input  logic [1:0]      cfg_dir,
  output logic            halt_req,
  output logic            wp_hit,
  output logic [NCMP-1:0] hit_src,
  output logic [NCMP-1:0] status
);
  logic [NCMP-1:0] fire;
  logic [NCMP-1:0] halt_mode;
  logic [NCMP-1:0] sticky;

  generate
    for (genvar i = 0; i < NCMP; i++) begin : g_slot
      localparam bit IS_DATA = (i == NUM_I);
      logic          load;
      logic          b_valid;
      logic          b_write;
      logic [AW-1:0] b_addr;

      always_comb begin
        load    = cfg_we && (cfg_idx == IW'(i));
        b_valid = IS_DATA ? db_valid : if_valid;
        b_write = IS_DATA ? db_write : 1'b0;
        b_addr  = IS_DATA ? db_addr  : if_addr;
      end

      bpwp_slot #(.AW(AW), .CW(CW), .IS_DATA(IS_DATA)) i_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (load),
        .cfg_addr   (cfg_addr),
        .cfg_count  (cfg_count),
        .cfg_halt   (cfg_halt),
        .cfg_enable (cfg_enable),
        .cfg_dir    (cfg_dir),
        .bus_valid  (b_valid),
        .bus_write  (b_write),
        .bus_addr   (b_addr),
        .fire       (fire[i]),
        .halt_mode  (halt_mode[i]),
        .sticky     (sticky[i])
      );
    end
  endgenerate

  always_comb begin
    hit_src  = fire;
    status   = sticky;
    halt_req = |(fire & halt_mode);
    wp_hit   = |(fire & ~halt_mode);
  end
endmodule

// File: rtl/bpwp_chk.sv
module bpwp_chk #(
  parameter int NUM_I = 2,
  localparam int NCMP = NUM_I + 1,
  localparam int IW   = (NCMP > 1) ? $clog2(NCMP) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            if_valid,
  input logic            db_valid,
  input logic            cfg_we,
  input logic [IW-1:0]   cfg_idx,
  input logic            halt_req,
  input logic            wp_hit,
  input logic [NCMP-1:0] hit_src,
  input logic [NCMP-1:0] status
);
  AST_EVENT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_src != '0) |-> $past(if_valid || db_valid)); // R1

  AST_LINES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || wp_hit) == (hit_src != '0)); // R3

  generate
    for (genvar i = 0; i < NCMP; i++) begin : g_chk
      AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_src[i] |=> !hit_src[i]); // R4

      AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hit_src[i] |-> status[i]); // R6

      AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[i] && !(cfg_we && cfg_idx == IW'(i))) |=> status[i]); // R6

      AST_CFG_BLOCKS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx == IW'(i)) |=> !hit_src[i]); // R8
    end
  endgenerate
endmodule

bind bpwp_unit bpwp_chk #(.NUM_I(NUM_I)) i_bpwp_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .if_valid (if_valid),
  .db_valid (db_valid),
  .cfg_we   (cfg_we),
  .cfg_idx  (cfg_idx),
  .halt_req (halt_req),
  .wp_hit   (wp_hit),
  .hit_src  (hit_src),
  .status   (status)
);

// File: tb/test_bpwp_unit.sv
`timescale 1ns/1ps
module test_bpwp_unit;
  localparam int AW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          if_valid, db_valid, db_write, cfg_we, cfg_halt, cfg_enable;
  logic [AW-1:0] if_addr, db_addr, cfg_addr;
  logic [1:0]    cfg_idx, cfg_dir;
  logic [CW-1:0] cfg_count;
  logic          halt_req, wp_hit;
  logic [2:0]    hit_src, status;

  int checks = 0;
  int fails  = 0;

  // expected {hit_src, halt_req, wp_hit, status}
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  bpwp_unit #(.NUM_I(2), .AW(AW), .CW(CW)) i_bpwp_unit (
    .clk(clk), .rst_n(rst_n),
    .if_valid(if_valid), .if_addr(if_addr),
    .db_valid(db_valid), .db_write(db_write), .db_addr(db_addr),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr),
    .cfg_count(cfg_count), .cfg_halt(cfg_halt), .cfg_enable(cfg_enable),
    .cfg_dir(cfg_dir),
    .halt_req(halt_req), .wp_hit(wp_hit), .hit_src(hit_src), .status(status)
  );

  task automatic compare(input logic [7:0] exp, input string tag);
    logic [7:0] got;
    got = {hit_src, halt_req, wp_hit, status};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got src=%b halt=%b wp=%b st=%b, expected src=%b halt=%b wp=%b st=%b",
               tag, got[7:5], got[4], got[3], got[2:0], exp[7:5], exp[4], exp[3], exp[2:0]);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: pops one expectation per clock edge, samples after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic idle();
    if_valid = 0; if_addr = '0; db_valid = 0; db_write = 0; db_addr = '0;
    cfg_we = 0; cfg_idx = '0; cfg_addr = '0; cfg_count = '0;
    cfg_halt = 0; cfg_enable = 0; cfg_dir = '0;
  endtask

  // driver: inputs are set at a falling edge; expectation for the next edge is queued
  task automatic tick(input logic [2:0] src, input logic h, input logic w,
                      input logic [2:0] st, input string tag);
    exp_q.push_back({src, h, w, st});
    tag_q.push_back(tag);
    @(negedge clk);
    idle();
  endtask

  task automatic cfg(input logic [1:0] idx, input logic [AW-1:0] a, input logic [CW-1:0] n,
                     input logic h, input logic en, input logic [1:0] d,
                     input logic [2:0] st, input string tag);
    cfg_we = 1; cfg_idx = idx; cfg_addr = a; cfg_count = n;
    cfg_halt = h; cfg_enable = en; cfg_dir = d;
    tick(3'b000, 0, 0, st, tag);
  endtask

  task automatic fetch(input logic [AW-1:0] a, input logic [2:0] src, input logic h,
                       input logic w, input logic [2:0] st, input string tag);
    if_valid = 1; if_addr = a;
    tick(src, h, w, st, tag);
  endtask

  task automatic data(input logic wr, input logic [AW-1:0] a, input logic [2:0] src,
                      input logic h, input logic w, input logic [2:0] st, input string tag);
    db_valid = 1; db_write = wr; db_addr = a;
    tick(src, h, w, st, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    compare(8'h00, "R6 reset state");
    rst_n = 1;
    @(negedge clk);

    // R2/R3: third fetch match fires a halt, then R5 stays silent
    cfg(2'd0, 16'h0100, 8'd3, 1, 1, 2'b00, 3'b000, "R2 cfg c0");
    fetch(16'h0100, 3'b000, 0, 0, 3'b000, "R2 match 1 of 3");
    fetch(16'h0104, 3'b000, 0, 0, 3'b000, "R1 other address");
    fetch(16'h0100, 3'b000, 0, 0, 3'b000, "R2 match 2 of 3");
    fetch(16'h0100, 3'b001, 1, 0, 3'b001, "R3 halt on 3rd match");
    fetch(16'h0100, 3'b000, 0, 0, 3'b001, "R5 disarmed after fire");

    // R2: count 0 fires at first match, watch mode
    cfg(2'd1, 16'h0200, 8'd0, 0, 1, 2'b00, 3'b001, "R6 other slot keeps status");
    fetch(16'h0200, 3'b010, 0, 1, 3'b011, "R3 watch count0");

    // R6 clear on reconfig, R1 invalid fetch ignored
    cfg(2'd0, 16'h0100, 8'd1, 1, 1, 2'b00, 3'b010, "R6 reconfig clears status");
    if_addr = 16'h0100;
    tick(3'b000, 0, 0, 3'b010, "R1 invalid fetch ignored");
    fetch(16'h0100, 3'b001, 1, 0, 3'b011, "R2 count1 first match");

    // R7 data comparator reads only, count 2
    cfg(2'd2, 16'h0040, 8'd2, 0, 1, 2'b01, 3'b011, "R7 cfg read filter");
    data(1, 16'h0040, 3'b000, 0, 0, 3'b011, "R7 write ignored");
    data(0, 16'h0040, 3'b000, 0, 0, 3'b011, "R7 read 1 of 2");
    data(0, 16'h0040, 3'b100, 0, 1, 3'b111, "R7 read 2 of 2 watch");

    // R7 writes only, halt mode
    cfg(2'd2, 16'h0040, 8'd1, 1, 1, 2'b10, 3'b011, "R7 cfg write filter");
    data(0, 16'h0040, 3'b000, 0, 0, 3'b011, "R7 read ignored");
    data(1, 16'h0040, 3'b100, 1, 0, 3'b111, "R7 write halts");

    // R7 dir 00 matches nothing
    cfg(2'd2, 16'h0040, 8'd1, 0, 1, 2'b00, 3'b011, "R7 cfg dir none");
    data(1, 16'h0040, 3'b000, 0, 0, 3'b011, "R7 dir none write");
    data(0, 16'h0040, 3'b000, 0, 0, 3'b011, "R7 dir none read");

    // R8 reconfig restarts the count; same-cycle match not counted
    cfg(2'd1, 16'h0300, 8'd2, 0, 1, 2'b00, 3'b001, "R8 cfg c1 count2");
    fetch(16'h0300, 3'b000, 0, 0, 3'b001, "R8 match 1 of 2");
    cfg_we = 1; cfg_idx = 2'd1; cfg_addr = 16'h0300; cfg_count = 8'd2;
    cfg_halt = 0; cfg_enable = 1; if_valid = 1; if_addr = 16'h0300;
    tick(3'b000, 0, 0, 3'b001, "R8 cfg wins over match");
    fetch(16'h0300, 3'b000, 0, 0, 3'b001, "R8 count restarted");
    fetch(16'h0300, 3'b010, 0, 1, 3'b011, "R8 fires after restart");

    // R9 disabled comparator
    cfg(2'd0, 16'h0500, 8'd1, 1, 0, 2'b00, 3'b010, "R9 cfg disabled");
    fetch(16'h0500, 3'b000, 0, 0, 3'b010, "R9 disabled no fire");

    // R10 two comparators at once, halt and watch together
    cfg(2'd0, 16'h0600, 8'd1, 1, 1, 2'b00, 3'b010, "R10 cfg c0");
    cfg(2'd1, 16'h0600, 8'd1, 0, 1, 2'b00, 3'b000, "R10 cfg c1");
    fetch(16'h0600, 3'b011, 1, 1, 3'b011, "R10 simultaneous fire");
    tick(3'b000, 0, 0, 3'b011, "R4 pulse lasts one cycle");

    summary();
  end
endmodule